// File: doc/BRIEF.md
# Ring Bypass Forwarding Unit

This unit sits at one node of a mesh and carries traffic around the node's router while that router is powered down or still coming back up. Flits that arrive on the ring input are steered by their head flit: a packet addressed to this node goes straight to the local ejection queue, and any other packet is captured in a one-entry forwarding latch that drives the ring output. Packets from the local injection queue also leave through that same latch, so the node stays both a source and a sink on the ring without the router.

The ring outputs of all nodes feed the ring inputs of their neighbours, forming one unidirectional loop that keeps every node reachable. A router power input tells the unit when the router is fully up; from then on no new packet is taken on either bypass path, but any packet already in flight is finished so that nothing is cut in half. Ring traffic in transit is favoured over local injection, and the two sources never interleave flits inside a packet.

A flit is `{kind[1:0], dest[ID_W-1:0], data[DATA_W-1:0]}` with kind at the top. Kind 2'b01 is a head, 2'b00 a body, 2'b10 a tail and 2'b11 a single-flit packet (head and tail at once). Only the head's destination field steers; the rest of the packet follows the head.

Top module: `ring_bypass_node`

## Requirements
- R1: During and after synchronous reset, `ring_out_valid` and `ej_valid` are 0 and the ring input is ready for a forwarded flit.
- R2: A ring packet whose head `dest` equals `node_id` is delivered on the ejection port, every flit of it (whatever its own dest field) appearing on `ej_flit` in the cycle after it is accepted.
- R3: A ring packet whose head `dest` differs from `node_id` appears on `ring_out_flit` in the cycle after acceptance and never on the ejection port.
- R4: When the unit is idle and a forwarded ring head and a local head are both offered, the ring flit is accepted and the local one is refused.
- R5: A local packet may start only when the forwarding latch is empty; while it holds a flit, `inj_ready` stays 0 for a head.
- R6: Once a head from one source is accepted into the latch, the other source is refused until that packet's tail has been accepted, so flits of two packets never interleave on the ring output.
- R7: While the ejection register is full and `ej_ready` is 0, a ring flit bound for ejection is refused (`ring_in_ready` = 0).
- R8: While `router_awake` is 1, no new packet is accepted on the ring input or the injection port, but a ring or local packet already started is accepted to its tail.
- R9: An output whose valid is 1 while its ready is 0 keeps valid high and its flit unchanged on the next cycle.
- R10: A single-flit packet leaves no ownership behind: the other source may be accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W | Address of this node |
| router_awake | input | 1 | 1 when the router is fully powered; bypass takes no new packets |
| ring_in_valid | input | 1 | Ring input flit valid |
| ring_in_ready | output | 1 | Ring input flit accepted this cycle when valid |
| ring_in_flit | input | FLIT_W | Ring input flit |
| ring_out_valid | output | 1 | Forwarding latch holds a flit |
| ring_out_ready | input | 1 | Next node takes the flit |
| ring_out_flit | output | FLIT_W | Flit leaving on the ring |
| ej_valid | output | 1 | Ejection register holds a flit |
| ej_ready | input | 1 | Ejection queue not full |
| ej_flit | output | FLIT_W | Flit to the ejection queue |
| inj_valid | input | 1 | Injection queue offers a flit |
| inj_ready | output | 1 | Injection flit accepted this cycle when valid |
| inj_flit | input | FLIT_W | Flit from the injection queue |

## Verification
Both outputs are registered once, so a flit accepted at a clock edge is due on `ring_out_flit` or `ej_flit` one cycle later, while the ready outputs are combinational and answer in the same cycle as the offer. The bench drives on the falling edge, reads the ready signals a moment later in that same half cycle, and reads the data outputs at the next falling edge, exactly one accepting edge after the offer. Stall and ownership cases are checked cycle by cycle across the whole window in which a refusal must hold, and again in the first cycle it must lift.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

  localparam logic [1:0] KIND_BODY   = 2'b00;
  localparam logic [1:0] KIND_HEAD   = 2'b01;
  localparam logic [1:0] KIND_TAIL   = 2'b10;
  localparam logic [1:0] KIND_SINGLE = 2'b11;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_RING  = 2'd1,
    OWN_LOCAL = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    RM_IDLE  = 2'd0,
    RM_EJECT = 2'd1,
    RM_FWD   = 2'd2
  } rmode_e;

  function automatic logic kind_head(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_tail(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/rbp_stage.sv
module rbp_stage #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      data_q <= in_data;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

// File: rtl/rbp_steer.sv
module rbp_steer
  import rbp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int FLIT_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic              router_awake,
  input  logic [FLIT_W-1:0] flit,
  input  logic              fire,
  output logic              dir_eject,
  output logic              may_accept,
  output logic              fwd_pkt
);

  localparam int KIND_MSB = FLIT_W - 1;
  localparam int DEST_MSB = FLIT_W - 3;

  rmode_e            mode_q;
  logic [1:0]        kind;
  logic [ID_W-1:0]   dest;

  assign kind = flit[KIND_MSB -: 2];
  assign dest = flit[DEST_MSB -: ID_W];

  assign may_accept = (mode_q != RM_IDLE) || !router_awake;
  assign dir_eject  = (mode_q == RM_EJECT) || ((mode_q == RM_IDLE) && (dest == node_id));
  assign fwd_pkt    = (mode_q == RM_FWD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RM_IDLE;
    end else if (fire) begin
      if (kind_tail(kind)) begin
        mode_q <= RM_IDLE;
      end else if ((mode_q == RM_IDLE) && kind_head(kind)) begin
        mode_q <= dir_eject ? RM_EJECT : RM_FWD;
      end
    end
  end

endmodule

// File: rtl/rbp_arbiter.sv
module rbp_arbiter
  import rbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       router_awake,
  input  logic       ring_req,
  input  logic [1:0] ring_kind,
  input  logic       inj_valid,
  input  logic [1:0] inj_kind,
  input  logic       lat_full,
  input  logic       lat_in_ready,
  output logic       ring_may,
  output logic       ring_go,
  output logic       inj_go,
  output logic       inj_ready,
  output logic       ring_owns
);

  owner_e owner_q;
  logic   inj_may;
  logic   ring_fire;
  logic   inj_fire;

  assign ring_may  = (owner_q == OWN_RING) || (owner_q == OWN_NONE);
  assign ring_go   = ring_req && ring_may;
  assign inj_may   = (owner_q == OWN_LOCAL) ||
                     ((owner_q == OWN_NONE) && !router_awake && !ring_req &&
                      !lat_full && kind_head(inj_kind));
  assign inj_go    = inj_valid && inj_may;
  assign inj_ready = inj_may && lat_in_ready;
  assign ring_fire = ring_go && lat_in_ready;
  assign inj_fire  = inj_go && lat_in_ready;
  assign ring_owns = (owner_q == OWN_RING);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
    end else if (ring_fire) begin
      if (kind_tail(ring_kind)) owner_q <= OWN_NONE;
      else if (kind_head(ring_kind)) owner_q <= OWN_RING;
    end else if (inj_fire) begin
      if (kind_tail(inj_kind)) owner_q <= OWN_NONE;
      else if (kind_head(inj_kind)) owner_q <= OWN_LOCAL;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(ring_go && inj_go)); // R6

  AST_INJ_START_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (inj_fire && (owner_q == OWN_NONE)) |-> !lat_full); // R5

endmodule

// File: rtl/ring_bypass_node.sv
module ring_bypass_node
  import rbp_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 16,
  parameter int FLIT_W = 2 + ID_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic              router_awake,
  input  logic              ring_in_valid,
  output logic              ring_in_ready,
  input  logic [FLIT_W-1:0] ring_in_flit,
  output logic              ring_out_valid,
  input  logic              ring_out_ready,
  output logic [FLIT_W-1:0] ring_out_flit,
  output logic              ej_valid,
  input  logic              ej_ready,
  output logic [FLIT_W-1:0] ej_flit,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [FLIT_W-1:0] inj_flit
);

  localparam int KIND_MSB = FLIT_W - 1;
  localparam int DEST_MSB = FLIT_W - 3;

  logic              dir_eject, may_accept, fwd_pkt;
  logic              ring_may, ring_go, inj_go, ring_owns;
  logic              ring_req, ring_fire;
  logic              lat_in_valid, lat_in_ready;
  logic [FLIT_W-1:0] lat_in_data;
  logic              ej_in_valid, ej_in_ready;

  rbp_steer #(.ID_W(ID_W), .FLIT_W(FLIT_W)) u_steer (
    .clk          (clk),
    .rst          (rst),
    .node_id      (node_id),
    .router_awake (router_awake),
    .flit         (ring_in_flit),
    .fire         (ring_fire),
    .dir_eject    (dir_eject),
    .may_accept   (may_accept),
    .fwd_pkt      (fwd_pkt)
  );

  assign ring_req      = ring_in_valid && may_accept && !dir_eject;
  assign ej_in_valid   = ring_in_valid && may_accept && dir_eject;
  assign ring_in_ready = may_accept && (dir_eject ? ej_in_ready : (ring_may && lat_in_ready));
  assign ring_fire     = ring_in_valid && ring_in_ready;

  rbp_arbiter u_arb (
    .clk          (clk),
    .rst          (rst),
    .router_awake (router_awake),
    .ring_req     (ring_req),
    .ring_kind    (ring_in_flit[KIND_MSB -: 2]),
    .inj_valid    (inj_valid),
    .inj_kind     (inj_flit[KIND_MSB -: 2]),
    .lat_full     (ring_out_valid),
    .lat_in_ready (lat_in_ready),
    .ring_may     (ring_may),
    .ring_go      (ring_go),
    .inj_go       (inj_go),
    .inj_ready    (inj_ready),
    .ring_owns    (ring_owns)
  );

  assign lat_in_valid = ring_go || inj_go;
  assign lat_in_data  = ring_go ? ring_in_flit : inj_flit;

  rbp_stage #(.W(FLIT_W)) u_fwd_latch (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (lat_in_valid),
    .in_ready  (lat_in_ready),
    .in_data   (lat_in_data),
    .out_valid (ring_out_valid),
    .out_ready (ring_out_ready),
    .out_data  (ring_out_flit)
  );

  rbp_stage #(.W(FLIT_W)) u_ej_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ej_in_valid),
    .in_ready  (ej_in_ready),
    .in_data   (ring_in_flit),
    .out_valid (ej_valid),
    .out_ready (ej_ready),
    .out_data  (ej_flit)
  );

  AST_OWNER_MATCH: assert property (@(posedge clk) disable iff (rst)
    ring_owns == fwd_pkt); // R6

  AST_EJ_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (ej_in_valid && ej_in_ready && !fwd_pkt && kind_head(ring_in_flit[KIND_MSB -: 2]))
      |-> (ring_in_flit[DEST_MSB -: ID_W] == node_id)); // R2

  AST_EJ_STALL: assert property (@(posedge clk) disable iff (rst)
    (ring_in_valid && dir_eject && ej_valid && !ej_ready) |-> !ring_in_ready); // R7

endmodule

// File: tb/tb_ring_bypass_node.sv
module tb_ring_bypass_node;

  localparam int ID_W   = 4;
  localparam int DATA_W = 16;
  localparam int FLIT_W = 2 + ID_W + DATA_W;
  localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_ONE = 2'b11;
  localparam logic [ID_W-1:0] MY_ID = 4'd5;

  logic clk = 1'b0;
  logic rst;
  logic [ID_W-1:0] node_id;
  logic router_awake;
  logic ring_in_valid, ring_in_ready;
  logic [FLIT_W-1:0] ring_in_flit;
  logic ring_out_valid, ring_out_ready;
  logic [FLIT_W-1:0] ring_out_flit;
  logic ej_valid, ej_ready;
  logic [FLIT_W-1:0] ej_flit;
  logic inj_valid, inj_ready;
  logic [FLIT_W-1:0] inj_flit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ring_bypass_node #(.ID_W(ID_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .node_id(node_id), .router_awake(router_awake),
    .ring_in_valid(ring_in_valid), .ring_in_ready(ring_in_ready), .ring_in_flit(ring_in_flit),
    .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready), .ring_out_flit(ring_out_flit),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_flit(ej_flit),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_flit(inj_flit)
  );

  function automatic logic [FLIT_W-1:0] mk(input logic [1:0] k, input logic [ID_W-1:0] d,
                                           input logic [DATA_W-1:0] v);
    return {k, d, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {dest, data, expect_eject}; single-flit packets, node_id = 5
  localparam logic [20:0] VEC [8] = '{
    {4'd5,  16'h1111, 1'b1},
    {4'd2,  16'h2222, 1'b0},
    {4'd5,  16'h3333, 1'b1},
    {4'd15, 16'h4444, 1'b0},
    {4'd0,  16'h5555, 1'b0},
    {4'd5,  16'hA5A5, 1'b1},
    {4'd4,  16'h0000, 1'b0},
    {4'd6,  16'hFFFF, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [FLIT_W-1:0] fa, fb, fc;
    rst = 1'b1; node_id = MY_ID; router_awake = 1'b0;
    ring_in_valid = 1'b0; ring_in_flit = '0; ring_out_ready = 1'b1;
    ej_ready = 1'b1; inj_valid = 1'b0; inj_flit = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!ring_out_valid, "R1 ring_out_valid in reset", ring_out_valid, 0);
    check(!ej_valid, "R1 ej_valid in reset", ej_valid, 0);
    @(negedge clk); rst = 1'b0; #1;
    check(!ring_out_valid && !ej_valid, "R1 outputs after reset", {ring_out_valid, ej_valid}, 0);
    check(ring_in_ready, "R1 ring input ready", ring_in_ready, 1);

    // vector table: R2 / R3 single flits
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      fa = mk(K_ONE, VEC[i][20:17], VEC[i][16:1]);
      ring_in_flit = fa; ring_in_valid = 1'b1; #1;
      check(ring_in_ready, "R2/R3 vector accepted", ring_in_ready, 1);
      @(negedge clk); ring_in_valid = 1'b0; #1;
      if (VEC[i][0]) begin
        check(ej_valid && ej_flit == fa, "R2 ejected flit", ej_flit, fa);
        check(!ring_out_valid, "R2 not forwarded", ring_out_valid, 0);
      end else begin
        check(ring_out_valid && ring_out_flit == fa, "R3 forwarded flit", ring_out_flit, fa);
        check(!ej_valid, "R3 not ejected", ej_valid, 0);
      end
    end
    @(negedge clk); @(negedge clk);

    // R4 / R5 / R10
    ring_out_ready = 1'b0;
    fa = mk(K_ONE, 4'd2, 16'hAAAA);
    fb = mk(K_ONE, 4'd9, 16'hBBBB);
    ring_in_flit = fa; ring_in_valid = 1'b1; inj_flit = fb; inj_valid = 1'b1; #1;
    check(ring_in_ready, "R4 ring wins", ring_in_ready, 1);
    check(!inj_ready, "R4 local refused", inj_ready, 0);
    @(negedge clk); ring_in_valid = 1'b0; #1;
    check(ring_out_valid && ring_out_flit == fa, "R4 ring flit out", ring_out_flit, fa);
    for (int c = 0; c < 3; c++) begin
      check(!inj_ready, "R5 injection waits on full latch", inj_ready, 0);
      @(negedge clk); #1;
    end
    check(ring_out_flit == fa, "R9 latch held under backpressure", ring_out_flit, fa);
    ring_out_ready = 1'b1; #1;
    check(!inj_ready, "R5 waits while latch still holds flit", inj_ready, 0);
    @(negedge clk); #1;
    check(inj_ready, "R5 injection after latch empties", inj_ready, 1);
    @(negedge clk); inj_valid = 1'b0; #1;
    check(ring_out_valid && ring_out_flit == fb, "R5 injected flit out", ring_out_flit, fb);
    fc = mk(K_ONE, 4'd3, 16'hCCCC);
    ring_in_flit = fc; ring_in_valid = 1'b1; #1;
    check(ring_in_ready, "R10 ring right after local single", ring_in_ready, 1);
    @(negedge clk); ring_in_valid = 1'b0; #1;
    check(ring_out_flit == fc, "R10 ring flit out", ring_out_flit, fc);
    @(negedge clk); @(negedge clk);

    // R6 no interleave
    inj_flit = mk(K_HEAD, 4'd3, 16'h0101); inj_valid = 1'b1; #1;
    check(inj_ready, "R6 local head accepted", inj_ready, 1);
    @(negedge clk);
    inj_flit = mk(K_BODY, 4'd0, 16'h0202);
    ring_in_flit = mk(K_HEAD, 4'd7, 16'h0707); ring_in_valid = 1'b1; #1;
    check(!ring_in_ready, "R6 ring blocked during local packet", ring_in_ready, 0);
    check(inj_ready, "R6 local body continues", inj_ready, 1);
    @(negedge clk); #1;
    check(ring_out_flit == mk(K_BODY, 4'd0, 16'h0202), "R6 local body out", ring_out_flit, 0);
    inj_flit = mk(K_TAIL, 4'd0, 16'h0303); #1;
    check(!ring_in_ready, "R6 ring blocked until tail", ring_in_ready, 0);
    @(negedge clk); inj_valid = 1'b0; #1;
    check(ring_out_flit == mk(K_TAIL, 4'd0, 16'h0303), "R6 local tail out", ring_out_flit, 0);
    check(ring_in_ready, "R6 ring after local tail", ring_in_ready, 1);
    @(negedge clk);
    check(ring_out_flit == mk(K_HEAD, 4'd7, 16'h0707), "R6 ring head out", ring_out_flit, 0);
    ring_in_flit = mk(K_TAIL, 4'd0, 16'h0808);
    inj_flit = mk(K_ONE, 4'd1, 16'h0909); inj_valid = 1'b1; #1;
    check(!inj_ready, "R6 local blocked during ring packet", inj_ready, 0);
    check(ring_in_ready, "R6 ring tail accepted", ring_in_ready, 1);
    @(negedge clk); ring_in_valid = 1'b0; #1;
    check(ring_out_flit == mk(K_TAIL, 4'd0, 16'h0808), "R6 ring tail out", ring_out_flit, 0);
    @(negedge clk); #1;
    check(inj_ready, "R6 local after ring tail", inj_ready, 1);
    @(negedge clk); inj_valid = 1'b0; #1;
    check(ring_out_flit == mk(K_ONE, 4'd1, 16'h0909), "R6 local flit out", ring_out_flit, 0);
    @(negedge clk);

    // R7 / R9 ejection backpressure
    ej_ready = 1'b0;
    fa = mk(K_ONE, MY_ID, 16'hE001);
    fb = mk(K_ONE, MY_ID, 16'hE002);
    ring_in_flit = fa; ring_in_valid = 1'b1; #1;
    check(ring_in_ready, "R7 first eject accepted", ring_in_ready, 1);
    @(negedge clk); ring_in_flit = fb; #1;
    check(ej_valid && ej_flit == fa, "R7 first eject held", ej_flit, fa);
    check(!ring_in_ready, "R7 ring stalls on full ejection", ring_in_ready, 0);
    @(negedge clk); #1;
    check(ej_valid && ej_flit == fa, "R9 ejection flit stable", ej_flit, fa);
    check(!ring_in_ready, "R7 still stalled", ring_in_ready, 0);
    ej_ready = 1'b1; #1;
    check(ring_in_ready, "R7 stall lifts", ring_in_ready, 1);
    @(negedge clk); ring_in_valid = 1'b0; #1;
    check(ej_valid && ej_flit == fb, "R7 second eject out", ej_flit, fb);
    @(negedge clk); #1;
    check(!ej_valid, "R7 ejection drained", ej_valid, 0);

    // R8 router awake
    router_awake = 1'b1;
    fa = mk(K_HEAD, MY_ID, 16'hD001);
    ring_in_flit = fa; ring_in_valid = 1'b1;
    inj_flit = mk(K_ONE, 4'd1, 16'hD0D0); inj_valid = 1'b1; #1;
    check(!ring_in_ready, "R8 no new ring packet while awake", ring_in_ready, 0);
    check(!inj_ready, "R8 no new local packet while awake", inj_ready, 0);
    @(negedge clk); #1;
    check(!ring_out_valid && !ej_valid, "R8 nothing taken while awake", {ring_out_valid, ej_valid}, 0);
    inj_valid = 1'b0; router_awake = 1'b0; #1;
    check(ring_in_ready, "R8 head taken while router off", ring_in_ready, 1);
    @(negedge clk); router_awake = 1'b1;
    fb = mk(K_BODY, 4'd0, 16'hD002);
    ring_in_flit = fb; #1;
    check(ej_flit == fa, "R2 head ejected", ej_flit, fa);
    check(ring_in_ready, "R8 body completes after wake", ring_in_ready, 1);
    @(negedge clk);
    fc = mk(K_TAIL, 4'd9, 16'hD003);
    ring_in_flit = fc; #1;
    check(ej_flit == fb, "R2 body follows head to ejection", ej_flit, fb);
    check(!ring_out_valid, "R2 body not forwarded", ring_out_valid, 0);
    check(ring_in_ready, "R8 tail completes after wake", ring_in_ready, 1);
    @(negedge clk);
    ring_in_flit = mk(K_ONE, MY_ID, 16'hD004); #1;
    check(ej_flit == fc, "R2 tail follows head to ejection", ej_flit, fc);
    check(!ring_in_ready, "R8 refused after packet done", ring_in_ready, 0);
    ring_in_valid = 1'b0; router_awake = 1'b0;
    @(negedge clk); @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule